// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a core between performance operating points. An operating point is a core-to-bus frequency ratio together with a voltage identifier (VID) code. A parameter array maps each ratio to its VID code. Software starts a transition by writing a target ratio through a single write port. The block then drives the VID and core ratio outputs in an order that keeps the supply voltage high enough for the running ratio. When the ratio rises, the voltage is raised first. When the ratio falls, the ratio is lowered first and the voltage follows.

The VID moves one code at a time, and one code stands for 12.5 mV. After every code step the block holds for a settle count. After every ratio switch it holds for a fixed relock count, which models the clock generator locking again. Only the core ratio output changes. The bus clock is not touched. A busy flag and a status word let software follow the progress of a transition. A write that arrives during a transition is parked, and only the newest parked target is kept.

Top module: `vfs_sequencer`

## Requirements
- R1: After reset, `ratio_o` equals RESET_RATIO (default 8), `vid_o` equals the table code for that ratio (default table: code = 32 + 2·ratio, so 48), `busy_o` is low and the pending bit of `stat_o` is clear.
- R2: For a target ratio above the present ratio, `vid_o` climbs to the target's code before `ratio_o` changes. `ratio_o` changes once, while `vid_o` already holds the target code.
- R3: For a target ratio below the present ratio, `ratio_o` switches first while `vid_o` is unchanged. Only after that does `vid_o` descend to the target's code.
- R4: Every change of `vid_o` is exactly one code up or down. A transition makes exactly |code(target) − code(present)| changes.
- R5: Between two successive VID changes, and between the last upward VID change and the ratio switch, at least SETTLE_CYC (default 3) cycles of settling pass, so changes are at least SETTLE_CYC+1 cycles apart.
- R6: After a ratio switch, `vid_o` stays still for RELOCK_CYC (default 5) cycles, so the next VID change comes at least RELOCK_CYC+1 cycles after the switch.
- R7: A written ratio above MAX_RATIO (default 20) is clamped to MAX_RATIO. `ratio_o` never exceeds MAX_RATIO.
- R8: `busy_o` rises in the cycle after the accepted write and stays high until the transition ends. A change of k codes keeps it high for 2 + RELOCK_CYC + k·(1+SETTLE_CYC) cycles. While idle, `vid_o` equals the code for `ratio_o`.
- R9: A write during a transition is held and runs once the current transition is over, with `busy_o` staying high. A later write replaces an earlier pending one, so an overwritten target is never applied. The pending bit implies busy.
- R10: A write whose clamped ratio equals the present ratio raises `busy_o` for exactly one cycle and changes neither `vid_o` nor `ratio_o`.
- R11: `stat_o` layout:

  | Bits | Meaning |
  | --- | --- |
  | [RATIO_W+3] | busy |
  | [RATIO_W+2] | pending write held |
  | [RATIO_W+1] | transition direction is upward |
  | [RATIO_W] | relock wait running |
  | [RATIO_W-1:0] | most recently accepted (clamped) target ratio |

- R12: At every cycle, `vid_o` is at least the table code of the current `ratio_o`.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Core-side control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the target ratio register |
| wr_ratio | input | RATIO_W | Requested core-to-bus ratio |
| vid_o | output | VID_W | Current voltage identifier code |
| ratio_o | output | RATIO_W | Current core-to-bus ratio |
| busy_o | output | 1 | Transition in progress or pending |
| stat_o | output | RATIO_W+4 | Status readback word (layout in R11) |

## Verification
The checker watches the safety relations on every cycle:
- unit VID steps;
- voltage never below the code of the running ratio;
- the voltage already at target when the ratio rises;
- the voltage still when the ratio falls;
- the minimum settle and relock spacing, which counters keep track of;
- the ratio ceiling;
- pending implying busy.

Only the bench scenarios can show the results that depend on the whole transition:
- the exact busy length for each size of step;
- the final operating point;
- that a pending target overwritten during a transition is never applied;
- that an equal write is a one-cycle no-op;
- that reset in mid-transition brings back the reset point.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

  localparam int DEF_RATIO_W   = 5;
  localparam int DEF_VID_W     = 8;
  localparam int DEF_MAX_RATIO = 20;
  localparam int DEF_VID_BASE  = 32;
  localparam int DEF_VID_SLOPE = 2;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_RISE      = 3'd1,
    PH_RISE_HOLD = 3'd2,
    PH_RELOCK    = 3'd3,
    PH_FALL      = 3'd4,
    PH_FALL_HOLD = 3'd5
  } phase_t;

  // Default ratio-to-code table: one entry per ratio, monotonic.
  function automatic logic [(DEF_MAX_RATIO+1)*DEF_VID_W-1:0] default_vid_lut();
    logic [(DEF_MAX_RATIO+1)*DEF_VID_W-1:0] t;
    t = '0;
    for (int r = 0; r <= DEF_MAX_RATIO; r++) begin
      t[r*DEF_VID_W +: DEF_VID_W] = DEF_VID_W'(DEF_VID_BASE + DEF_VID_SLOPE * r);
    end
    return t;
  endfunction

  // Wider of two counts, used to size the shared wait timer.
  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vfs_ratio_map.sv
module vfs_ratio_map #(
  parameter int RATIO_W   = 5,
  parameter int VID_W     = 8,
  parameter int MAX_RATIO = 20,
  parameter logic [(MAX_RATIO+1)*VID_W-1:0] VID_LUT = vfs_pkg::default_vid_lut()
) (
  input  logic [RATIO_W-1:0] raw_ratio,
  output logic [RATIO_W-1:0] safe_ratio,
  output logic [VID_W-1:0]   safe_vid
);

  localparam logic [RATIO_W-1:0] CEIL = RATIO_W'(MAX_RATIO);

  logic [VID_W-1:0] code_tbl [MAX_RATIO+1];

  genvar g;
  generate
    for (g = 0; g <= MAX_RATIO; g++) begin : g_tbl
      assign code_tbl[g] = VID_LUT[g*VID_W +: VID_W];
    end
  endgenerate

  assign safe_ratio = (raw_ratio > CEIL) ? CEIL : raw_ratio;
  assign safe_vid   = code_tbl[int'(safe_ratio)];

endmodule

// File: rtl/vfs_req_latch.sv
module vfs_req_latch #(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic               take,
  output logic               pend_vld,
  output logic [RATIO_W-1:0] pend_ratio
);

  // Newest write always wins; a write in the same cycle as take re-arms.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_ratio <= '0;
    end else if (wr_en) begin
      pend_vld   <= 1'b1;
      pend_ratio <= wr_ratio;
    end else if (take) begin
      pend_vld   <= 1'b0;
    end
  end

endmodule

// File: rtl/vfs_wait_timer.sv
module vfs_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last,
  output logic             running
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last    = (cnt == CNT_W'(1));
  assign running = (cnt != '0);

endmodule

// File: rtl/vfs_sequencer.sv
module vfs_sequencer #(
  parameter int RATIO_W     = vfs_pkg::DEF_RATIO_W,
  parameter int VID_W       = vfs_pkg::DEF_VID_W,
  parameter int MAX_RATIO   = vfs_pkg::DEF_MAX_RATIO,
  parameter int RESET_RATIO = 8,
  parameter int SETTLE_CYC  = 3,
  parameter int RELOCK_CYC  = 5,
  parameter logic [(MAX_RATIO+1)*VID_W-1:0] VID_LUT = vfs_pkg::default_vid_lut()
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_ratio,
  output logic [VID_W-1:0]   vid_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               busy_o,
  output logic [RATIO_W+3:0] stat_o
);

  import vfs_pkg::*;

  localparam int TMR_W = $clog2(max_of(SETTLE_CYC, RELOCK_CYC) + 1);
  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RESET_RATIO);
  localparam logic [VID_W-1:0]   RST_VID   = VID_LUT[RESET_RATIO*VID_W +: VID_W];
  localparam logic [TMR_W-1:0]   SETTLE_LD = TMR_W'(SETTLE_CYC);
  localparam logic [TMR_W-1:0]   RELOCK_LD = TMR_W'(RELOCK_CYC);

  // State
  phase_t             phase;
  logic [RATIO_W-1:0] cur_ratio;
  logic [VID_W-1:0]   cur_vid;
  logic [RATIO_W-1:0] tgt_ratio;
  logic [VID_W-1:0]   tgt_vid;
  logic               dir_up;

  // Request path
  logic               pend_vld;
  logic [RATIO_W-1:0] pend_ratio;
  logic [RATIO_W-1:0] req_ratio;
  logic [VID_W-1:0]   req_vid;

  // Named internal events
  logic accept_ev;
  logic req_same;
  logic req_up;
  logic req_down;
  logic vid_up_ev;
  logic vid_dn_ev;
  logic vid_step_ev;
  logic ratio_sw_ev;
  logic settle_done;
  logic relock_wait;

  // Timer controls
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_last;
  logic             tmr_run;

  vfs_req_latch #(.RATIO_W(RATIO_W)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_ratio   (wr_ratio),
    .take       (accept_ev),
    .pend_vld   (pend_vld),
    .pend_ratio (pend_ratio)
  );

  vfs_ratio_map #(
    .RATIO_W   (RATIO_W),
    .VID_W     (VID_W),
    .MAX_RATIO (MAX_RATIO),
    .VID_LUT   (VID_LUT)
  ) u_map (
    .raw_ratio  (pend_ratio),
    .safe_ratio (req_ratio),
    .safe_vid   (req_vid)
  );

  vfs_wait_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last),
    .running  (tmr_run)
  );

  // Event decode
  assign accept_ev   = (phase == PH_IDLE) && pend_vld;
  assign req_same    = accept_ev && (req_ratio == cur_ratio);
  assign req_up      = accept_ev && (req_ratio >  cur_ratio);
  assign req_down    = accept_ev && (req_ratio <  cur_ratio);
  assign vid_up_ev   = (phase == PH_RISE) && (cur_vid < tgt_vid);
  assign vid_dn_ev   = (phase == PH_FALL) && (cur_vid > tgt_vid);
  assign vid_step_ev = vid_up_ev || vid_dn_ev;
  assign ratio_sw_ev = req_down || ((phase == PH_RISE) && !(cur_vid < tgt_vid));
  assign relock_wait = (phase == PH_RELOCK) && tmr_run;
  assign settle_done = ((phase == PH_RISE_HOLD) || (phase == PH_FALL_HOLD)) && tmr_last;

  // Timer load: a VID step arms the settle wait, a ratio switch arms relock.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = SETTLE_LD;
    if (vid_step_ev) begin
      tmr_load = 1'b1;
      tmr_val  = SETTLE_LD;
    end else if (ratio_sw_ev) begin
      tmr_load = 1'b1;
      tmr_val  = RELOCK_LD;
    end
  end

  // Phase machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_ratio <= RST_RATIO;
      cur_vid   <= RST_VID;
      tgt_ratio <= RST_RATIO;
      tgt_vid   <= RST_VID;
      dir_up    <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (accept_ev) begin
            tgt_ratio <= req_ratio;
            tgt_vid   <= req_vid;
            if (req_up) begin
              dir_up <= 1'b1;
              phase  <= PH_RISE;
            end else if (req_down) begin
              dir_up    <= 1'b0;
              cur_ratio <= req_ratio;
              phase     <= PH_RELOCK;
            end else begin
              dir_up <= 1'b0;
            end
          end
        end
        PH_RISE: begin
          if (vid_up_ev) begin
            cur_vid <= cur_vid + 1'b1;
            phase   <= PH_RISE_HOLD;
          end else begin
            cur_ratio <= tgt_ratio;
            phase     <= PH_RELOCK;
          end
        end
        PH_RISE_HOLD: begin
          if (settle_done) phase <= PH_RISE;
        end
        PH_RELOCK: begin
          if (tmr_last) phase <= dir_up ? PH_IDLE : PH_FALL;
        end
        PH_FALL: begin
          if (vid_dn_ev) begin
            cur_vid <= cur_vid - 1'b1;
            phase   <= PH_FALL_HOLD;
          end else begin
            phase <= PH_IDLE;
          end
        end
        PH_FALL_HOLD: begin
          if (settle_done) phase <= PH_FALL;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Outputs
  assign vid_o   = cur_vid;
  assign ratio_o = cur_ratio;
  assign busy_o  = (phase != PH_IDLE) || pend_vld;
  assign stat_o  = {busy_o, pend_vld, dir_up && (phase != PH_IDLE), relock_wait, tgt_ratio};

endmodule

// File: rtl/vfs_checker.sv
module vfs_checker #(
  parameter int RATIO_W    = 5,
  parameter int VID_W      = 8,
  parameter int MAX_RATIO  = 20,
  parameter int SETTLE_CYC = 3,
  parameter int RELOCK_CYC = 5,
  parameter logic [(MAX_RATIO+1)*VID_W-1:0] VID_LUT = vfs_pkg::default_vid_lut()
) (
  input logic               clk,
  input logic               rst_n,
  input logic [VID_W-1:0]   vid_o,
  input logic [RATIO_W-1:0] ratio_o,
  input logic               busy_o,
  input logic [RATIO_W+3:0] stat_o,
  input logic               vid_step_ev,
  input logic               relock_wait
);

  localparam int AGE_MAX = SETTLE_CYC + RELOCK_CYC + 2;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  function automatic logic [VID_W-1:0] code_of(input logic [RATIO_W-1:0] r);
    int idx;
    idx = (int'(r) > MAX_RATIO) ? MAX_RATIO : int'(r);
    return VID_LUT[idx*VID_W +: VID_W];
  endfunction

  logic [VID_W-1:0]   prev_vid;
  logic [RATIO_W-1:0] prev_ratio;
  logic [AGE_W-1:0]   v_age;
  logic [AGE_W-1:0]   r_age;
  logic               vid_chg;
  logic               r_chg;

  assign vid_chg = (vid_o != prev_vid);
  assign r_chg   = (ratio_o != prev_ratio);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_vid   <= vid_o;
      prev_ratio <= ratio_o;
      v_age      <= AGE_W'(AGE_MAX);
      r_age      <= AGE_W'(AGE_MAX);
    end else begin
      prev_vid   <= vid_o;
      prev_ratio <= ratio_o;
      if (vid_chg) v_age <= '0;
      else if (v_age != AGE_W'(AGE_MAX)) v_age <= v_age + 1'b1;
      if (r_chg) r_age <= '0;
      else if (r_age != AGE_W'(AGE_MAX)) r_age <= r_age + 1'b1;
    end
  end

  p_up_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_o > prev_ratio) |-> (!vid_chg && vid_o == code_of(ratio_o)));

  p_down_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_o < prev_ratio) |-> (!vid_chg && vid_o == code_of(prev_ratio)));

  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vid_chg |-> ((vid_o == prev_vid + 1'b1) || (vid_o + 1'b1 == prev_vid)));

  p_settle_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_chg || (ratio_o > prev_ratio)) |-> (int'(v_age) >= SETTLE_CYC));

  p_relock_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vid_chg |-> (int'(r_age) >= RELOCK_CYC));

  p_step_not_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vid_step_ev |-> !relock_wait);

  p_ratio_ceiling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ratio_o) <= MAX_RATIO);

  p_idle_settled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (vid_o == code_of(ratio_o)));

  p_pend_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[RATIO_W+2] |-> busy_o);

  p_safe_vid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vid_o >= code_of(ratio_o));

endmodule

bind vfs_sequencer vfs_checker #(
  .RATIO_W    (RATIO_W),
  .VID_W      (VID_W),
  .MAX_RATIO  (MAX_RATIO),
  .SETTLE_CYC (SETTLE_CYC),
  .RELOCK_CYC (RELOCK_CYC),
  .VID_LUT    (VID_LUT)
) u_vfs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .vid_o       (vid_o),
  .ratio_o     (ratio_o),
  .busy_o      (busy_o),
  .stat_o      (stat_o),
  .vid_step_ev (vid_step_ev),
  .relock_wait (relock_wait)
);

// File: tb/tb_vfs_sequencer.sv
module tb_vfs_sequencer;

  localparam int RW   = 5;
  localparam int VW   = 8;
  localparam int MAXR = 20;
  localparam int RSTR = 8;
  localparam int SET  = 3;
  localparam int RLK  = 5;
  localparam int NVEC = 8;
  // {written ratio, expected final ratio}
  localparam int VEC [NVEC][2] = '{
    '{12, 12}, '{5, 5}, '{20, 20}, '{9, 9},
    '{31, 20}, '{20, 20}, '{0, 0}, '{7, 7}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [RW-1:0] wr_ratio = '0;
  logic [VW-1:0] vid_o;
  logic [RW-1:0] ratio_o;
  logic          busy_o;
  logic [RW+3:0] stat_o;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  vfs_sequencer dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_ratio (wr_ratio),
    .vid_o    (vid_o),
    .ratio_o  (ratio_o),
    .busy_o   (busy_o),
    .stat_o   (stat_o)
  );

  // Code of a ratio as stated in R1: 32 plus two per ratio unit.
  function automatic int bvid(input int r);
    return 32 + r * 2;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_write(input int r);
    @(negedge clk);
    wr_en    = 1'b1;
    wr_ratio = RW'(r);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic watch_xfer(input int from_r, input int to_r, input string tag);
    int k, exp_busy, cyc, pv, pr, nv, nr, first_v, last_v, r_at, maxr;
    bit bad_step, bad_gap, bad_rl;
    k = iabs(bvid(to_r) - bvid(from_r));
    exp_busy = (to_r == from_r) ? 1 : (2 + RLK + k * (1 + SET));
    cyc = 0; pv = int'(vid_o); pr = int'(ratio_o); nv = 0; nr = 0;
    first_v = -1; last_v = -1; r_at = -1; maxr = pr;
    bad_step = 0; bad_gap = 0; bad_rl = 0;
    while (1) begin
      @(negedge clk);
      if (!busy_o || cyc > 4000) break;
      cyc++;
      if (int'(vid_o) != pv) begin
        if (iabs(int'(vid_o) - pv) != 1) bad_step = 1;
        if (last_v >= 0 && cyc - last_v < SET + 1) bad_gap = 1;
        if (r_at >= 0 && cyc - r_at < RLK + 1) bad_rl = 1;
        if (first_v < 0) first_v = cyc;
        last_v = cyc;
        nv++;
      end
      if (int'(ratio_o) != pr) begin
        if (last_v >= 0 && cyc - last_v < SET + 1) bad_gap = 1;
        r_at = cyc;
        nr++;
      end
      if (int'(ratio_o) > maxr) maxr = int'(ratio_o);
      pv = int'(vid_o);
      pr = int'(ratio_o);
    end
    chk(cyc == exp_busy, "R8", {tag, " busy length"}, cyc, exp_busy);
    chk(int'(vid_o) == bvid(to_r), "R4", {tag, " final vid"}, int'(vid_o), bvid(to_r));
    chk(nv == k && !bad_step, "R4", {tag, " unit step count"}, nv, k);
    chk(!bad_gap, "R5", {tag, " settle spacing"}, bad_gap, 0);
    chk(!bad_rl, "R6", {tag, " relock quiet"}, bad_rl, 0);
    chk(maxr <= MAXR, "R7", {tag, " ratio ceiling"}, maxr, MAXR);
    chk(int'(stat_o[RW-1:0]) == to_r, "R11", {tag, " status target"}, int'(stat_o[RW-1:0]), to_r);
    if (to_r > from_r) begin
      chk(int'(ratio_o) == to_r && nr == 1, "R2", {tag, " up final ratio"}, int'(ratio_o), to_r);
      chk(last_v < r_at, "R2", {tag, " vid before ratio"}, last_v, r_at);
    end else if (to_r < from_r) begin
      chk(int'(ratio_o) == to_r && nr == 1, "R3", {tag, " down final ratio"}, int'(ratio_o), to_r);
      chk(first_v > r_at, "R3", {tag, " ratio before vid"}, first_v, r_at);
    end else begin
      chk(nr == 0 && nv == 0 && int'(ratio_o) == to_r, "R10", {tag, " equal write no change"}, nr + nv, 0);
    end
  endtask

  initial begin : main
    int cur;
    bit saw15, saw10, dropped;
    int pcyc;
    // Reset state (R1)
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(ratio_o) == RSTR, "R1", "reset ratio", int'(ratio_o), RSTR);
    chk(int'(vid_o) == bvid(RSTR), "R1", "reset vid", int'(vid_o), bvid(RSTR));
    chk(!busy_o && !stat_o[RW+2], "R1", "reset busy/pending", int'(busy_o), 0);

    // Vector table walk
    cur = RSTR;
    for (int i = 0; i < NVEC; i++) begin
      do_write(VEC[i][0]);
      watch_xfer(cur, VEC[i][1], $sformatf("vec%0d", i));
      cur = VEC[i][1];
    end

    // Pending overwrite (R9) and status bits (R11): 7 -> 10, then 15 replaced by 3
    do_write(10);
    repeat (3) @(negedge clk);
    chk(stat_o[RW+3] && stat_o[RW+1], "R11", "busy and up bits", int'(stat_o[RW+3:RW+1]), 5);
    do_write(15);
    repeat (2) @(negedge clk);
    do_write(3);
    @(negedge clk);
    chk(stat_o[RW+2] == 1'b1, "R9", "pending bit set", int'(stat_o[RW+2]), 1);
    chk(int'(stat_o[RW-1:0]) == 10, "R9", "running target kept", int'(stat_o[RW-1:0]), 10);
    saw15 = 0; saw10 = 0; dropped = 0; pcyc = 0;
    while (busy_o && pcyc < 4000) begin
      if (int'(ratio_o) == 15) saw15 = 1;
      if (int'(ratio_o) == 10) saw10 = 1;
      @(negedge clk);
      pcyc++;
    end
    chk(saw10, "R9", "first target reached", int'(saw10), 1);
    chk(!saw15, "R9", "overwritten target skipped", int'(saw15), 0);
    chk(int'(ratio_o) == 3, "R9", "latest target applied", int'(ratio_o), 3);
    chk(int'(vid_o) == bvid(3), "R9", "latest target vid", int'(vid_o), bvid(3));
    @(negedge clk);
    chk(!busy_o && int'(ratio_o) == 3, "R8", "stays idle after chain", int'(busy_o), 0);

    // Clamp directly (R7): from 3 write 25 -> 20
    do_write(25);
    watch_xfer(3, 20, "clamp25");

    // Reset during a transition (R1)
    do_write(2);
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(ratio_o) == RSTR && int'(vid_o) == bvid(RSTR), "R1", "mid-transition reset point",
        int'(ratio_o), RSTR);
    chk(!busy_o, "R1", "mid-transition reset idle", int'(busy_o), 0);

    // Equal write after reset (R10)
    do_write(RSTR);
    watch_xfer(RSTR, RSTR, "equal8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule